// File: doc/BRIEF.md
# Dual-Channel Service Request Controller

This block manages the service-request flags of two output channels. Each channel owns a request latch and an enable latch. The request latch can be set in one of two ways, chosen per channel by a static strap input. In timer mode, a settle timer is restarted by every value change of the channel. When the timer expires, the request is raised, which tells the host that the channel output has become valid. In external mode, a rising edge on the channel's external request input raises the request instead.

Bus commands, each a 5-bit function code and a 4-bit sub-address, act on the latches. They can test a request after the enable gate, test it before the gate, test whether a channel has settled, clear requests, and enable or disable requests. A separate general-clear input clears and disables both channels. A clear-and-disable-all command has the same effect. Test commands answer on `q_out` in the same cycle the command is presented. State-changing commands take effect at the next clock edge.

The combined request line is high whenever any channel has both its request and its enable latch set. The settle time is given in microseconds and converted to clock cycles using the clock frequency parameter.

Top module: `lam_ctrl`

## Requirements
- R1: After reset, both request latches and both enable latches are clear, `lam_out` is 0, and both channels report settled.
- R2: In timer mode (`ext_sel[i]`=0), a one-cycle `val_chg[i]` pulse registered at edge E sets request i at edge E+SETTLE_CYC, and not before. Channel i reads as not settled from E until that same edge. SETTLE_CYC = CLK_FREQ_HZ/1e6 * SETTLE_US.
- R3: A new `val_chg[i]` pulse while the timer is running restarts the full settle interval from the new pulse.
- R4: In external mode (`ext_sel[i]`=1), a rising edge of `ext_req[i]` sets request i and timer expiry does not. A level held high does not set it again. In timer mode, `ext_req[i]` is ignored.
- R5: Function 8 returns Q=1 for sub-address 0 or 1 when channel A or B (respectively) has its request and enable both set. Sub-address 15 returns Q=1 when either channel does.
- R6: Function 27, sub-address 0 or 1, returns Q=1 when the request of channel A or B is set, regardless of enable. Sub-address 2 or 3 returns Q=1 when channel A or B has settled.
- R7: Function 10 with sub-address 0 clears only the channel A request. With sub-address 15 it clears both requests.
- R8: Function 24 disables and function 26 enables channel A (sub-address 0), channel B (sub-address 1) or both (sub-address 15).
- R9: `bus_clr`, or function 9 with sub-address 15, clears both requests and both enables.
- R10: `lam_out` is the OR over channels of (request AND enable).
- R11: When a request is set and cleared in the same cycle, the set wins.
- R12: Any other function/sub-address pair gives Q=0 and changes no state. `q_out` is 0 when `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clr | input | 1 | General clear: clears and disables both requests |
| cmd_valid | input | 1 | Command strobe for the current cycle |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Sub-address |
| val_chg | input | 2 | One-cycle value-change pulse per channel |
| ext_req | input | 2 | External request input per channel |
| ext_sel | input | 2 | Strap: 1 selects the external request source |
| lam_out | output | 1 | Combined enabled service request |
| q_out | output | 1 | Q response of a test command |

## Verification
The hardest case to reach is a retrigger of the settle timer. A second value change must land partway through the interval, and the request must stay low for a full new interval and rise on exactly the right edge. The bench places the second pulse a few cycles into the first interval. It then probes the raw request one edge before and one edge after the expected rise. Enable and request combinations are reached quickly through the external strap, so every test command can be swept over all sixteen states.

// File: rtl/lam_pkg.sv
package lam_pkg;
    localparam int NCH = 2;

    localparam logic [4:0] FN_TEST_EN  = 5'd8;
    localparam logic [4:0] FN_CLR_ALL  = 5'd9;
    localparam logic [4:0] FN_CLR_REQ  = 5'd10;
    localparam logic [4:0] FN_DISABLE  = 5'd24;
    localparam logic [4:0] FN_ENABLE   = 5'd26;
    localparam logic [4:0] FN_TEST_RAW = 5'd27;

    localparam logic [3:0] SUB_BOTH = 4'd15;

    typedef struct packed {
        logic clr_req;
        logic en_set;
        logic en_clr;
    } chan_ctl_t;
endpackage

// File: rtl/lam_decode.sv
module lam_decode
    import lam_pkg::*;
(
    input  logic                  cmd_valid,
    input  logic [4:0]            cmd_func,
    input  logic [3:0]            cmd_sub,
    input  logic                  bus_clr,
    input  logic [NCH-1:0]        req,
    input  logic [NCH-1:0]        en,
    input  logic [NCH-1:0]        stable,
    output chan_ctl_t [NCH-1:0]   ctl,
    output logic                  q
);
    logic clr_all;

    always_comb begin
        clr_all = bus_clr || (cmd_valid && cmd_func == FN_CLR_ALL && cmd_sub == SUB_BOTH);
        for (int i = 0; i < NCH; i++) begin
            ctl[i].clr_req = clr_all ||
                (cmd_valid && cmd_func == FN_CLR_REQ &&
                 (cmd_sub == SUB_BOTH || (i == 0 && cmd_sub == 4'd0)));
            ctl[i].en_clr  = clr_all ||
                (cmd_valid && cmd_func == FN_DISABLE &&
                 (cmd_sub == SUB_BOTH || cmd_sub == 4'(i)));
            ctl[i].en_set  = cmd_valid && cmd_func == FN_ENABLE &&
                 (cmd_sub == SUB_BOTH || cmd_sub == 4'(i));
        end
    end

    always_comb begin
        q = 1'b0;
        if (cmd_valid) begin
            if (cmd_func == FN_TEST_EN) begin
                if (cmd_sub == 4'd0 || cmd_sub == 4'd1)
                    q = req[cmd_sub[0]] && en[cmd_sub[0]];
                else if (cmd_sub == SUB_BOTH)
                    q = |(req & en);
            end else if (cmd_func == FN_TEST_RAW) begin
                if (cmd_sub == 4'd0 || cmd_sub == 4'd1)
                    q = req[cmd_sub[0]];
                else if (cmd_sub == 4'd2 || cmd_sub == 4'd3)
                    q = stable[cmd_sub[0]];
            end
        end
    end
endmodule

// File: rtl/lam_chan.sv
module lam_chan
    import lam_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chg,
    input  logic      ext_req,
    input  logic      use_ext,
    input  chan_ctl_t ctl,
    output logic      req,
    output logic      en,
    output logic      stable
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             en;
        logic             ext_q;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     expire, set_req;

    always_comb begin
        st_d       = st_q;
        st_d.ext_q = ext_req;
        expire     = !chg && st_q.cnt == CNT_W'(1);
        if (chg)
            st_d.cnt = CNT_W'(SETTLE_CYC);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CNT_W'(1);
        set_req = use_ext ? (ext_req && !st_q.ext_q) : expire;
        if (set_req)
            st_d.req = 1'b1;
        else if (ctl.clr_req)
            st_d.req = 1'b0;
        if (ctl.en_clr)
            st_d.en = 1'b0;
        else if (ctl.en_set)
            st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req    = st_q.req;
    assign en     = st_q.en;
    assign stable = st_q.cnt == '0;
endmodule

// File: rtl/lam_ctrl.sv
module lam_ctrl
    import lam_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int SETTLE_US   = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clr,
    input  logic       cmd_valid,
    input  logic [4:0] cmd_func,
    input  logic [3:0] cmd_sub,
    input  logic [1:0] val_chg,
    input  logic [1:0] ext_req,
    input  logic [1:0] ext_sel,
    output logic       lam_out,
    output logic       q_out
);
    localparam int SETTLE_CYC = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;

    logic [NCH-1:0]      req_v, en_v, stable_v;
    chan_ctl_t [NCH-1:0] ctl_v;

    lam_decode dec_i (
        .cmd_valid (cmd_valid),
        .cmd_func  (cmd_func),
        .cmd_sub   (cmd_sub),
        .bus_clr   (bus_clr),
        .req       (req_v),
        .en        (en_v),
        .stable    (stable_v),
        .ctl       (ctl_v),
        .q         (q_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        lam_chan #(.SETTLE_CYC(SETTLE_CYC)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .chg     (val_chg[i]),
            .ext_req (ext_req[i]),
            .use_ext (ext_sel[i]),
            .ctl     (ctl_v[i]),
            .req     (req_v[i]),
            .en      (en_v[i]),
            .stable  (stable_v[i])
        );
    end

    assign lam_out = |(req_v & en_v);
endmodule

// File: rtl/lam_ctrl_chk.sv
module lam_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_clr,
    input logic       cmd_valid,
    input logic [4:0] cmd_func,
    input logic [3:0] cmd_sub,
    input logic [1:0] val_chg,
    input logic       lam_out,
    input logic       q_out,
    input logic [1:0] req_v,
    input logic [1:0] en_v,
    input logic [1:0] stable_v
);
    // R10
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v == 2'b00) |-> !lam_out);

    // R9
    general_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |=> (!lam_out && en_v == 2'b00));

    // R12
    q_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !q_out);

    // R2
    busy_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_chg[0] |=> !stable_v[0]);

    // R2
    busy_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_chg[1] |=> !stable_v[1]);

    // R8
    enable_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == 5'd26 && cmd_sub == 4'd15 && !bus_clr) |=> en_v == 2'b11);

    // R7
    clear_a_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == 5'd10 && cmd_sub == 4'd0) |=> $stable(req_v[1]) || req_v[1]);
endmodule

bind lam_ctrl lam_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_clr   (bus_clr),
    .cmd_valid (cmd_valid),
    .cmd_func  (cmd_func),
    .cmd_sub   (cmd_sub),
    .val_chg   (val_chg),
    .lam_out   (lam_out),
    .q_out     (q_out),
    .req_v     (req_v),
    .en_v      (en_v),
    .stable_v  (stable_v)
);

// File: tb/lam_ctrl_tb_top.sv
`timescale 1ns/100ps
module lam_ctrl_tb_top;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n, bus_clr, cmd_valid;
    logic [4:0] cmd_func;
    logic [3:0] cmd_sub;
    logic [1:0] val_chg, ext_req, ext_sel;
    logic       lam_out, q_out;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    lam_ctrl #(.CLK_FREQ_HZ(1_000_000), .SETTLE_US(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .cmd_valid(cmd_valid),
        .cmd_func(cmd_func), .cmd_sub(cmd_sub), .val_chg(val_chg),
        .ext_req(ext_req), .ext_sel(ext_sel), .lam_out(lam_out), .q_out(q_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input int f, input int a);
        cmd_valid = 1'b1; cmd_func = 5'(f); cmd_sub = 4'(a);
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic peek(input int f, input int a, input logic exp, input string tag);
        cmd_valid = 1'b1; cmd_func = 5'(f); cmd_sub = 4'(a);
        #0.2;
        chk(q_out, exp, tag);
        cmd_valid = 1'b0;
        #0.2;
    endtask

    task automatic pulse_chg(input int ch);
        val_chg[ch] = 1'b1;
        step();
        val_chg = 2'b00;
    endtask

    task automatic set_state(input logic [1:0] r, input logic [1:0] e);
        issue(9, 15);
        ext_sel = 2'b11;
        ext_req = r;
        step();
        ext_req = 2'b00;
        step();
        if (e[0]) issue(26, 0);
        if (e[1]) issue(26, 1);
        ext_sel = 2'b00;
    endtask

    function automatic logic exp_q(input int f, input int a, input logic [1:0] r,
                                   input logic [1:0] e, input logic [1:0] s);
        if (f == 8) begin
            if (a == 0 || a == 1) return r[a] & e[a];
            if (a == 15) return |(r & e);
        end else if (f == 27) begin
            if (a == 0 || a == 1) return r[a];
            if (a == 2 || a == 3) return s[a-2];
        end
        return 1'b0;
    endfunction

    function automatic logic acts(input int f, input int a);
        return f == 8 || f == 27 || (f == 9 && a == 15) ||
               (f == 10 && (a == 0 || a == 15)) ||
               ((f == 24 || f == 26) && (a == 0 || a == 1 || a == 15));
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_clr = 1'b0; cmd_valid = 1'b0; cmd_func = '0; cmd_sub = '0;
        val_chg = '0; ext_req = '0; ext_sel = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(lam_out, 1'b0, "R1 lam_out");
        peek(27, 0, 1'b0, "R1 raw A");
        peek(27, 1, 1'b0, "R1 raw B");
        peek(27, 2, 1'b1, "R1 settled A");
        peek(27, 3, 1'b1, "R1 settled B");
        step();
        peek(8, 15, 1'b0, "R1 enabled any");

        // R5 R6 R10 sweep over all request/enable states
        for (int r = 0; r < 4; r++) begin
            for (int e = 0; e < 4; e++) begin
                set_state(2'(r), 2'(e));
                chk(lam_out, |(2'(r) & 2'(e)), "R10 lam_out");
                for (int a = 0; a < 16; a++) begin
                    peek(8, a, exp_q(8, a, 2'(r), 2'(e), 2'b11), "R5 test enabled");
                    peek(27, a, exp_q(27, a, 2'(r), 2'(e), 2'b11), "R6 test raw");
                    step();
                end
            end
        end

        // R12 inert commands
        set_state(2'b11, 2'b01);
        for (int f = 0; f < 32; f++) begin
            for (int a = 0; a < 16; a++) begin
                if (!acts(f, a)) begin
                    peek(f, a, 1'b0, "R12 inert q");
                    cmd_valid = 1'b1;
                    step();
                    cmd_valid = 1'b0;
                end
            end
        end
        peek(27, 0, 1'b1, "R12 raw A kept");
        peek(27, 1, 1'b1, "R12 raw B kept");
        peek(8, 0, 1'b1, "R12 en A kept");
        peek(8, 1, 1'b0, "R12 en B kept");
        chk(lam_out, 1'b1, "R12 lam_out kept");

        // R7 clear requests
        set_state(2'b11, 2'b11);
        issue(10, 0);
        peek(27, 0, 1'b0, "R7 A cleared");
        peek(27, 1, 1'b1, "R7 B kept");
        step();
        issue(10, 15);
        peek(27, 1, 1'b0, "R7 both cleared");
        step();

        // R8 enable / disable
        set_state(2'b11, 2'b00);
        chk(lam_out, 1'b0, "R8 disabled lam");
        issue(26, 15);
        peek(8, 0, 1'b1, "R8 en both A");
        peek(8, 1, 1'b1, "R8 en both B");
        step();
        issue(24, 1);
        peek(8, 1, 1'b0, "R8 dis B");
        peek(27, 1, 1'b1, "R8 raw B through disable");
        chk(lam_out, 1'b1, "R8 lam via A");
        step();
        issue(24, 0);
        chk(lam_out, 1'b0, "R8 dis A lam");
        issue(26, 1);
        peek(8, 1, 1'b1, "R8 en B");
        step();
        issue(24, 15);
        peek(8, 15, 1'b0, "R8 dis both");
        step();

        // R9 general clear and clear-all command
        set_state(2'b11, 2'b11);
        bus_clr = 1'b1;
        step();
        bus_clr = 1'b0;
        chk(lam_out, 1'b0, "R9 bus_clr lam");
        peek(27, 0, 1'b0, "R9 bus_clr raw A");
        peek(27, 1, 1'b0, "R9 bus_clr raw B");
        step();
        ext_sel = 2'b11; ext_req = 2'b11; step(); ext_req = 2'b00; step();
        peek(27, 0, 1'b1, "R9 request after clr");
        peek(8, 15, 1'b0, "R9 enables cleared");
        step();
        ext_sel = 2'b00;
        set_state(2'b11, 2'b11);
        issue(9, 15);
        chk(lam_out, 1'b0, "R9 cmd lam");
        peek(27, 1, 1'b0, "R9 cmd raw B");
        step();

        // R2 settle timer per channel
        for (int ch = 0; ch < 2; ch++) begin
            issue(9, 15);
            issue(26, 15);
            pulse_chg(ch);
            peek(27, 2 + ch, 1'b0, "R2 busy after change");
            repeat (N - 1) step();
            peek(27, ch, 1'b0, "R2 raw one edge early");
            peek(27, 2 + ch, 1'b0, "R2 busy one edge early");
            chk(lam_out, 1'b0, "R2 lam early");
            step();
            peek(27, ch, 1'b1, "R2 raw on time");
            peek(27, 2 + ch, 1'b1, "R2 settled on time");
            peek(27, 1 - ch, 1'b0, "R2 other channel idle");
            chk(lam_out, 1'b1, "R2 lam on time");
            step();
        end

        // R3 retrigger
        issue(9, 15);
        pulse_chg(0);
        repeat (3) step();
        pulse_chg(0);
        repeat (N - 1) step();
        peek(27, 0, 1'b0, "R3 restarted early");
        step();
        peek(27, 0, 1'b1, "R3 restarted on time");
        step();

        // R4 external source
        issue(9, 15);
        ext_sel = 2'b01;
        pulse_chg(0);
        repeat (N + 2) step();
        peek(27, 0, 1'b0, "R4 timer ignored in ext mode");
        peek(27, 2, 1'b1, "R4 settles in ext mode");
        ext_req = 2'b01;
        step();
        peek(27, 0, 1'b1, "R4 ext edge sets");
        issue(10, 0);
        peek(27, 0, 1'b0, "R4 held level no reset");
        ext_req = 2'b00;
        step();
        ext_sel = 2'b00;
        issue(9, 15);
        ext_req = 2'b11;
        step();
        ext_req = 2'b00;
        peek(27, 0, 1'b0, "R4 ext ignored timer mode A");
        peek(27, 1, 1'b0, "R4 ext ignored timer mode B");
        step();

        // R11 set beats clear
        ext_sel = 2'b11;
        issue(9, 15);
        ext_req = 2'b11;
        cmd_valid = 1'b1; cmd_func = 5'd10; cmd_sub = 4'd15;
        step();
        cmd_valid = 1'b0; ext_req = 2'b00;
        peek(27, 0, 1'b1, "R11 set wins A");
        peek(27, 1, 1'b1, "R11 set wins B");
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule